// File: doc/BRIEF.md
# Protected Memory Window Checker

This block sits beside the physical address path of a processor core and tells, for every access it is shown, whether the address lies inside memory reserved for the system-management handler. Two windows are judged in parallel. The first is a fixed legacy window from A_0000h to B_FFFFh. The second can be relocated. Its position comes from a base register and its size comes from a mask register, and only address bits 51 through 17 take part in the match. Each window has its own enable bit. Both enable bits sit in the low bits of the mask register.

Software programs the two 64-bit registers through a simple write port and reads them back through a combinational read port. An access is presented as a 52-bit address with a valid strobe. One clock later the block returns a result strobe, a hit flag for each window, and a combined protected flag. What the bus does with a hit is left to the logic outside.

Top module: `smm_guard_top`

## Requirements
- R1: After reset both configuration registers read as zero, and no access reports a hit until software sets an enable bit.
- R2: Writes to the base register (select 0) keep only bits 51:17. Writes to the mask register (select 1) keep only bits 51:17, bit 1 and bit 0. Every other bit is dropped and reads back as zero.
- R3: When bit 0 of the mask register is 1, an access hits the fixed window exactly when its address lies between A_0000h and B_FFFFh, both ends included.
- R4: When bit 1 of the mask register is 1, an access hits the relocatable window exactly when (address[51:17] AND mask[51:17]) equals (base[51:17] AND mask[51:17]).
- R5: A window whose enable bit is 0 never reports a hit, whatever the address and the other register contents.
- R6: The result strobe and the hit flags appear on the clock edge after the one that samples the access strobe. In any cycle where the result strobe is low, all hit flags are low.
- R7: The protected flag is high exactly when at least one of the two window hit flags is high.
- R8: With base 0010_0000h and mask FFFC_0002h, the relocatable window covers 0010_0000h through 0013_FFFFh. The addresses just outside it do not hit.
- R9: The read port returns the base register when its select is 0 and the mask register when its select is 1, in the same cycle.
- R10: An access presented in the same cycle as a register write is judged against the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 base, 1 mask |
| cfg_wr_data | input | 64 | Write data |
| cfg_rd_sel | input | 1 | Read target: 0 base, 1 mask |
| cfg_rd_data | output | 64 | Selected register contents |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 52 | Physical address of the access |
| res_valid | output | 1 | Result strobe, one cycle after acc_valid |
| hit_fixed | output | 1 | Access hit the fixed window |
| hit_reloc | output | 1 | Access hit the relocatable window |
| hit_any | output | 1 | Access hit either window |

## Verification
The bound checker watches several things on every cycle. It checks the one-cycle relation between the access strobe and the result strobe. It checks that the hit flags stay quiet when no result is presented, and that the combined flag agrees with the per-window flags. It checks that a cleared enable bit suppresses its window, that an enabled window hits on a matching address, and that reserved register bits stay zero. Some behaviour needs the bench's scenarios. These are the exact window edges, the worked 256 KB example, read-back filtering of written patterns, and the rule that an access coinciding with a write uses the old values. The bench sweeps address bits across every enable combination and also runs pseudo-random base, mask and address patterns against an arithmetic model.

// File: rtl/smm_guard_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the protected window checker.
// Assumes a 52-bit physical address space and 64-bit configuration registers.
package smm_guard_pkg;
    localparam int unsigned ADDR_W    = 52;
    localparam int unsigned REG_W     = 64;
    localparam int unsigned FIELD_LO  = 17;
    localparam int unsigned FIELD_HI  = 51;
    localparam int unsigned EN_FIX    = 0;
    localparam int unsigned EN_REL    = 1;
    localparam longint unsigned FIX_LO = 64'h0000_0000_000A_0000;
    localparam longint unsigned FIX_HI = 64'h0000_0000_000B_FFFF;

    // Register selector shared by the write and read ports.
    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_MASK = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/smm_guard_regs.sv
`timescale 1ns/1ps
// Holds the base and mask registers of the relocatable window.
// Reserved bits are filtered on write, so they always hold and read zero.
// Assumes FIELD_HI < REG_W and both enable bits lie below FIELD_LO.
module smm_guard_regs
    import smm_guard_pkg::*;
#(
    parameter int unsigned R_W    = REG_W,
    parameter int unsigned F_LO   = FIELD_LO,
    parameter int unsigned F_HI   = FIELD_HI,
    parameter int unsigned E_FIX  = EN_FIX,
    parameter int unsigned E_REL  = EN_REL,
    localparam int unsigned FW    = F_HI - F_LO + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_sel,
    input  logic [R_W-1:0] wr_data,
    input  logic           rd_sel,
    output logic [R_W-1:0] rd_data,
    output logic [FW-1:0]  base_field,
    output logic [FW-1:0]  mask_field,
    output logic           en_fixed,
    output logic           en_reloc
);
    localparam logic [R_W-1:0] ONE        = R_W'(1);
    localparam logic [R_W-1:0] FIELD_KEEP = ((ONE << (F_HI + 1)) - ONE) ^ ((ONE << F_LO) - ONE);
    localparam logic [R_W-1:0] BASE_KEEP  = FIELD_KEEP;
    localparam logic [R_W-1:0] MASK_KEEP  = FIELD_KEEP | (ONE << E_FIX) | (ONE << E_REL);

    logic [R_W-1:0] base_q;
    logic [R_W-1:0] mask_q;

    // Base register: filtered write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en && (cfg_sel_e'(wr_sel) == SEL_BASE)) begin
            base_q <= wr_data & BASE_KEEP;
        end
    end

    // Mask register with enable bits: filtered write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && (cfg_sel_e'(wr_sel) == SEL_MASK)) begin
            mask_q <= wr_data & MASK_KEEP;
        end
    end

    // Combinational read-back of the selected register.
    always_comb begin
        rd_data = (cfg_sel_e'(rd_sel) == SEL_MASK) ? mask_q : base_q;
    end

    // Field slices handed to the comparators.
    always_comb begin
        base_field = base_q[F_HI:F_LO];
        mask_field = mask_q[F_HI:F_LO];
        en_fixed   = mask_q[E_FIX];
        en_reloc   = mask_q[E_REL];
    end
endmodule

// File: rtl/smm_guard_fixed_cmp.sv
`timescale 1ns/1ps
// Inclusive range test of an address against a fixed window.
// Assumes LO <= HI. Purely combinational.
module smm_guard_fixed_cmp
    import smm_guard_pkg::*;
#(
    parameter int unsigned     A_W = ADDR_W,
    parameter longint unsigned LO  = FIX_LO,
    parameter longint unsigned HI  = FIX_HI
) (
    input  logic [A_W-1:0] addr,
    input  logic           enable,
    output logic           hit
);
    localparam logic [A_W-1:0] LO_A = A_W'(LO);
    localparam logic [A_W-1:0] HI_A = A_W'(HI);

    // Two magnitude compares gated by the window enable.
    always_comb begin
        hit = enable && (addr >= LO_A) && (addr <= HI_A);
    end
endmodule

// File: rtl/smm_guard_masked_cmp.sv
`timescale 1ns/1ps
// Masked equality of an address field against a base field.
// A bit takes part only where the mask bit is 1. An all-zero mask matches everything.
module smm_guard_masked_cmp #(
    parameter int unsigned FW = 35
) (
    input  logic [FW-1:0] addr_field,
    input  logic [FW-1:0] base_field,
    input  logic [FW-1:0] mask_field,
    input  logic          enable,
    output logic          hit
);
    logic [FW-1:0] bit_miss;

    // One differing, masked-in bit per lane marks a miss.
    for (genvar i = 0; i < FW; i++) begin : g_lane
        assign bit_miss[i] = mask_field[i] & (addr_field[i] ^ base_field[i]);
    end

    // Reduce the lanes and apply the window enable.
    always_comb begin
        hit = enable && (bit_miss == '0);
    end
endmodule

// File: rtl/smm_guard_result.sv
`timescale 1ns/1ps
// Output register stage: captures the comparator results of a valid access.
// Flags are cleared in cycles without a result.
module smm_guard_result (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  logic raw_fixed,
    input  logic raw_reloc,
    output logic res_valid,
    output logic hit_fixed,
    output logic hit_reloc,
    output logic hit_any
);
    // Register strobe and hits, gated by the access strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            hit_fixed <= 1'b0;
            hit_reloc <= 1'b0;
            hit_any   <= 1'b0;
        end else begin
            res_valid <= acc_valid;
            hit_fixed <= acc_valid & raw_fixed;
            hit_reloc <= acc_valid & raw_reloc;
            hit_any   <= acc_valid & (raw_fixed | raw_reloc);
        end
    end
endmodule

// File: rtl/smm_guard_top.sv
`timescale 1ns/1ps
// Protected memory window checker, top level.
// Judges each valid access against a fixed window and a relocatable masked window.
// Results appear one cycle later. The registers used are those held before any
// write in the same cycle.
module smm_guard_top
    import smm_guard_pkg::*;
#(
    parameter int unsigned     A_W   = ADDR_W,
    parameter int unsigned     R_W   = REG_W,
    parameter int unsigned     F_LO  = FIELD_LO,
    parameter int unsigned     F_HI  = FIELD_HI,
    parameter longint unsigned W_LO  = FIX_LO,
    parameter longint unsigned W_HI  = FIX_HI,
    localparam int unsigned    FW    = F_HI - F_LO + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr_en,
    input  logic           cfg_wr_sel,
    input  logic [R_W-1:0] cfg_wr_data,
    input  logic           cfg_rd_sel,
    output logic [R_W-1:0] cfg_rd_data,
    input  logic           acc_valid,
    input  logic [A_W-1:0] acc_addr,
    output logic           res_valid,
    output logic           hit_fixed,
    output logic           hit_reloc,
    output logic           hit_any
);
    logic [FW-1:0] cfg_base;
    logic [FW-1:0] cfg_mask;
    logic          cfg_en_fixed;
    logic          cfg_en_reloc;
    logic          raw_fixed;
    logic          raw_reloc;

    smm_guard_regs #(
        .R_W  (R_W),
        .F_LO (F_LO),
        .F_HI (F_HI),
        .E_FIX(EN_FIX),
        .E_REL(EN_REL)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_sel    (cfg_wr_sel),
        .wr_data   (cfg_wr_data),
        .rd_sel    (cfg_rd_sel),
        .rd_data   (cfg_rd_data),
        .base_field(cfg_base),
        .mask_field(cfg_mask),
        .en_fixed  (cfg_en_fixed),
        .en_reloc  (cfg_en_reloc)
    );

    smm_guard_fixed_cmp #(
        .A_W(A_W),
        .LO (W_LO),
        .HI (W_HI)
    ) u_fixed (
        .addr  (acc_addr),
        .enable(cfg_en_fixed),
        .hit   (raw_fixed)
    );

    smm_guard_masked_cmp #(
        .FW(FW)
    ) u_reloc (
        .addr_field(acc_addr[F_HI:F_LO]),
        .base_field(cfg_base),
        .mask_field(cfg_mask),
        .enable    (cfg_en_reloc),
        .hit       (raw_reloc)
    );

    smm_guard_result u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .raw_fixed(raw_fixed),
        .raw_reloc(raw_reloc),
        .res_valid(res_valid),
        .hit_fixed(hit_fixed),
        .hit_reloc(hit_reloc),
        .hit_any  (hit_any)
    );
endmodule

// File: rtl/smm_guard_chk.sv
`timescale 1ns/1ps
// Property checker for smm_guard_top, attached with bind below.
// It observes the ports and the register fields handed to the comparators.
module smm_guard_chk #(
    parameter int unsigned A_W  = 52,
    parameter int unsigned R_W  = 64,
    parameter int unsigned F_LO = 17,
    parameter int unsigned F_HI = 51,
    localparam int unsigned FW  = F_HI - F_LO + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           acc_valid,
    input logic [A_W-1:0] acc_addr,
    input logic           cfg_rd_sel,
    input logic [R_W-1:0] cfg_rd_data,
    input logic [FW-1:0]  cfg_base,
    input logic [FW-1:0]  cfg_mask,
    input logic           cfg_en_fixed,
    input logic           cfg_en_reloc,
    input logic           res_valid,
    input logic           hit_fixed,
    input logic           hit_reloc,
    input logic           hit_any
);
    localparam logic [R_W-1:0] ONE   = R_W'(1);
    localparam logic [R_W-1:0] FKEEP = ((ONE << (F_HI + 1)) - ONE) ^ ((ONE << F_LO) - ONE);
    localparam logic [R_W-1:0] BRSV  = ~FKEEP;
    localparam logic [R_W-1:0] MRSV  = ~(FKEEP | ONE | (ONE << 1));

    logic fix_in_range;
    logic rel_match;
    assign fix_in_range = (acc_addr >= A_W'(64'hA0000)) && (acc_addr <= A_W'(64'hBFFFF));
    assign rel_match    = ((acc_addr[F_HI:F_LO] ^ cfg_base) & cfg_mask) == '0;

    // R6
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);
    // R6
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);
    // R6
    quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(hit_fixed || hit_reloc || hit_any));
    // R7
    any_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> (hit_fixed || hit_reloc));
    // R7
    any_implied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_fixed || hit_reloc) |-> hit_any);
    // R5
    fixed_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !cfg_en_fixed) |=> !hit_fixed);
    // R5
    reloc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !cfg_en_reloc) |=> !hit_reloc);
    // R3
    fixed_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cfg_en_fixed) |=> (hit_fixed == $past(fix_in_range)));
    // R4
    reloc_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cfg_en_reloc) |=> (hit_reloc == $past(rel_match)));
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_rd_data & (cfg_rd_sel ? MRSV : BRSV)) == '0));
endmodule

bind smm_guard_top smm_guard_chk #(
    .A_W (A_W),
    .R_W (R_W),
    .F_LO(F_LO),
    .F_HI(F_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .cfg_rd_sel  (cfg_rd_sel),
    .cfg_rd_data (cfg_rd_data),
    .cfg_base    (cfg_base),
    .cfg_mask    (cfg_mask),
    .cfg_en_fixed(cfg_en_fixed),
    .cfg_en_reloc(cfg_en_reloc),
    .res_valid   (res_valid),
    .hit_fixed   (hit_fixed),
    .hit_reloc   (hit_reloc),
    .hit_any     (hit_any)
);

// File: tb/tb_smm_guard_top.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps address bits over every enable combination and
// compares against an arithmetic model of the two windows.
module tb_smm_guard_top;
    localparam logic [63:0] FIELD  = 64'h000F_FFFF_FFFE_0000;
    localparam logic [63:0] MKEEP  = FIELD | 64'h3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [63:0] cfg_wr_data = '0;
    logic        cfg_rd_sel = 1'b0;
    logic [63:0] cfg_rd_data;
    logic        acc_valid = 1'b0;
    logic [51:0] acc_addr = '0;
    logic        res_valid, hit_fixed, hit_reloc, hit_any;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] m_base = '0;
    logic [63:0] m_mask = '0;
    logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

    always #4 clk = ~clk;

    smm_guard_top dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
        .acc_valid(acc_valid), .acc_addr(acc_addr),
        .res_valid(res_valid), .hit_fixed(hit_fixed), .hit_reloc(hit_reloc), .hit_any(hit_any)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    // Model: registers after write filtering (R2).
    task automatic write_reg(input logic sel, input logic [63:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (sel) m_mask = data & MKEEP; else m_base = data & FIELD;
    endtask

    function automatic logic [2:0] model(input logic [51:0] a);
        logic f, r;
        f = m_mask[0] && (a >= 52'hA0000) && (a <= 52'hBFFFF);
        r = m_mask[1] && ((({12'h0, a} & m_mask & FIELD)) == (m_base & m_mask & FIELD));
        return {f | r, r, f};
    endfunction

    // One access; the result is sampled one cycle later at the falling edge.
    task automatic access(input string req, input logic [51:0] a);
        logic [2:0] e;
        e = model(a);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        check({req, " R6 strobe"}, {63'h0, res_valid}, 64'h1);
        check({req, " flags"}, {61'h0, hit_any, hit_reloc, hit_fixed}, {61'h0, e});
        check("R7 combined", {63'h0, hit_any}, {63'h0, hit_fixed | hit_reloc});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cfg_rd_sel = 1'b0; #1;
        check("R1 base reset", cfg_rd_data, 64'h0);
        cfg_rd_sel = 1'b1; #1;
        check("R1 mask reset", cfg_rd_data, 64'h0);
        check("R1 outputs", {60'h0, res_valid, hit_fixed, hit_reloc, hit_any}, 64'h0);
        access("R1 no hit after reset", 52'hA8000);

        // R2 / R9: filtering and read select
        write_reg(1'b0, '1);
        write_reg(1'b1, '1);
        cfg_rd_sel = 1'b0; #1;
        check("R2 R9 base filter", cfg_rd_data, FIELD);
        cfg_rd_sel = 1'b1; #1;
        check("R2 R9 mask filter", cfg_rd_data, MKEEP);
        write_reg(1'b1, 64'hFFF0_0000_0001_FFFC);
        check("R2 mask reserved only", cfg_rd_data, 64'h0);
        write_reg(1'b0, 64'h0);

        // R8: 256 KB example
        write_reg(1'b0, 64'h0010_0000);
        write_reg(1'b1, 64'hFFFC_0002);
        access("R8 low edge", 52'h10_0000);
        access("R8 high edge", 52'h13_FFFF);
        access("R8 below", 52'h0F_FFFF);
        access("R8 above", 52'h14_0000);
        check("R8 above miss", {63'h0, hit_reloc}, 64'h0);

        // R3 R4 R5: sweep of every enable combination over address bits 23:15
        for (int en = 0; en < 4; en++) begin
            write_reg(1'b1, 64'h00FF_0000 | 64'(en));
            for (int hi = 0; hi < 512; hi++) begin
                access("R3 R4 R5 sweep", 52'(hi) << 15);
                access("R3 R4 R5 sweep top", (52'(hi) << 15) | 52'h7FFF);
            end
        end

        // R3: exact fixed edges with only the fixed window on
        write_reg(1'b1, 64'h1);
        access("R3 below", 52'h9FFFF);
        access("R3 first", 52'hA0000);
        access("R3 last", 52'hBFFFF);
        access("R3 past", 52'hC0000);
        access("R3 alias high", 52'h1_000A_0000);

        // R4: pseudo-random masks, bases and addresses
        for (int k = 0; k < 300; k++) begin
            seed = next_rand(seed);
            write_reg(1'b0, seed);
            seed = next_rand(seed);
            write_reg(1'b1, seed | 64'h2);
            for (int j = 0; j < 4; j++) begin
                seed = next_rand(seed);
                access("R4 random", (j[0]) ? 52'(seed) : (52'(m_base) | (52'(seed) & ~52'(m_mask))));
            end
        end

        // R6: idle cycles carry no result
        repeat (2) @(negedge clk);
        check("R6 idle", {60'h0, res_valid, hit_fixed, hit_reloc, hit_any}, 64'h0);

        // R10: access in the same cycle as a write uses the old registers
        write_reg(1'b1, 64'h1);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 52'hB0000;
        cfg_wr_en = 1'b1; cfg_wr_sel = 1'b1; cfg_wr_data = 64'h0;
        @(negedge clk);
        acc_valid = 1'b0; cfg_wr_en = 1'b0; m_mask = 64'h0;
        check("R10 old values used", {63'h0, hit_fixed}, 64'h1);
        access("R10 new values next", 52'hB0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule